// File: doc/BRIEF.md
# Span Z and Color Interpolator

This block walks one horizontal span of a rasterised primitive. It produces one pixel per clock. A single start pulse captures the whole span description: a start framebuffer address, a signed pixel count, a start depth with its slope, and a start value with a slope for each of three colour channels. The block then runs with no further help. For each pixel it presents the address, the integer depth and the packed colour. It checks the new depth against the depth already stored at that address, which comes from a combinational read port. It also gates the write with a 16-entry screen-door pattern.

Depth is unsigned fixed point. It has 12 fraction bits and either a 16-bit or a 24-bit integer part, chosen per span. Each colour is unsigned 8.12 fixed point. Every interpolated value clamps at the edges of its format instead of wrapping around. The sign of the count sets whether the address counts up or down. Each of three controls freezes one part of the stepping: depth, colour or address. A pseudo-colour control blanks the red and green channels.

Top module: `span_interp`

## Requirements
- R1: A start pulse seen while idle with a nonzero count makes `busy` high from the next cycle for exactly |count| cycles, one pixel per cycle. `done` is a one-cycle pulse in the first cycle with `busy` low again. A start with count 0 raises no `busy` and gives a `done` pulse in the next cycle.
- R2: A start pulse that arrives while `busy` is high is ignored. The span in progress keeps its length and its captured settings.
- R3: The first pixel address is the start address. Each later pixel adds +1 when the 13-bit two's-complement count is positive and -1 when it is negative, modulo 2^24. When the address-hold control is set, the address stays at the start address.
- R4: Depth is a 28-bit value (16.12) when `z24_en` is 0 and a 36-bit value (24.12) when it is 1. The start value is truncated to that width. Each later pixel adds the signed 36-bit slope and clamps the result to the range 0 to the all-ones format maximum. `fb_z` carries the integer part, bits [35:12], zero-extended to 24 bits. `z_interp_off` holds depth at its start value.
- R5: Each colour is 20 bits (8.12). Each later pixel adds its signed 20-bit slope and clamps the result to 0 to 0xFFFFF. `c_interp_off` holds all three at their start values. `fb_rgb` packs the integer parts: red in [23:16], green in [15:8], blue in [7:0].
- R6: With `pseudo_en` set, the red and green fields of `fb_rgb` are 0. Blue is unaffected.
- R7: The depth test compares the 24-bit integer depth with `fb_zold`. Condition bit 2 passes on new < stored, bit 1 on new > stored and bit 0 on equal. The test passes when any selected relation holds, so condition 0 never passes.
- R8: The screen-door mask bit indexed by `pix_addr[3:0]` must be 1 for a write to occur. A 0 bit suppresses that pixel.
- R9: `fb_we` is high only in a `busy` cycle whose pixel passes both the depth test and the mask. `fb_z` and `fb_rgb` are then the data written at `pix_addr`.
- R10: After reset, `busy`, `done` and `fb_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a span (sampled while idle) |
| span_cnt | input | 13 | Signed pixel count; the sign sets the direction |
| addr_start | input | 24 | First pixel address |
| z_start | input | 36 | Start depth, 24.12 layout |
| z_slope | input | 36 | Signed depth step per pixel |
| r_start | input | 20 | Red start, 8.12 |
| r_slope | input | 20 | Signed red step |
| g_start | input | 20 | Green start, 8.12 |
| g_slope | input | 20 | Signed green step |
| b_start | input | 20 | Blue start, 8.12 |
| b_slope | input | 20 | Signed blue step |
| sd_mask | input | 16 | Screen-door pattern indexed by address[3:0] |
| z_cond | input | 3 | Depth pass condition: less, greater, equal |
| z24_en | input | 1 | Select 24-bit depth integer |
| z_interp_off | input | 1 | Freeze depth |
| c_interp_off | input | 1 | Freeze colours |
| addr_hold | input | 1 | Freeze address |
| pseudo_en | input | 1 | Blank red and green |
| fb_zold | input | 24 | Stored depth at pix_addr (combinational read) |
| busy | output | 1 | Span in progress; one pixel per cycle |
| done | output | 1 | End-of-span pulse |
| pix_addr | output | 24 | Current pixel address |
| fb_we | output | 1 | Pixel write enable |
| fb_z | output | 24 | Depth integer to write |
| fb_rgb | output | 24 | Packed colour to write |

## Verification
The properties assume that `fb_zold` settles within the same cycle for whatever `pix_addr` shows. They also assume that the span settings matter only in the cycle that accepts `start`, because the block captures them there. The bench backs the read port with a small array indexed by `pix_addr[5:0]`, which it updates at the clock edge on `fb_we`. It changes inputs only on the falling edge, and it pulses `start` for a single cycle. The one exception is a deliberate pulse in the middle of a span, which checks that such a pulse is ignored.

// File: rtl/span_pkg.sv
package span_pkg;
    parameter int ADDR_W   = 24;
    parameter int CNT_W    = 13;
    parameter int ZFRAC_W  = 12;
    parameter int ZINT_NW  = 16;
    parameter int ZINT_WW  = 24;
    parameter int CINT_W   = 8;
    parameter int CFRAC_W  = 12;
    parameter int MASK_W   = 16;
    parameter int COND_W   = 3;
    parameter int NCH      = 3;

    localparam int ZW     = ZINT_WW + ZFRAC_W;
    localparam int ZNW    = ZINT_NW + ZFRAC_W;
    localparam int CW     = CINT_W + CFRAC_W;
    localparam int MIDX_W = $clog2(MASK_W);

    typedef struct packed {
        logic                      down;
        logic [ZW-1:0]             zsl;
        logic [NCH-1:0][CW-1:0]    csl;
        logic [MASK_W-1:0]         mask;
        logic [COND_W-1:0]         cond;
        logic                      z24;
        logic                      zoff;
        logic                      coff;
        logic                      ahold;
        logic                      pseudo;
    } span_cfg_t;

    typedef struct packed {
        logic                      busy;
        logic                      done;
        logic [ADDR_W-1:0]         addr;
        logic [ZW-1:0]             z;
        logic [NCH-1:0][CW-1:0]    col;
        logic [CNT_W-1:0]          left;
        span_cfg_t                 cfg;
    } span_st_t;

    function automatic logic [ZW-1:0] zlimit(input logic wide);
        return wide ? {ZW{1'b1}} : {{(ZW-ZNW){1'b0}}, {ZNW{1'b1}}};
    endfunction
endpackage

// File: rtl/span_satacc.sv
module span_satacc #(
    parameter int W = 20
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] slope,
    input  logic [W-1:0] lim,
    input  logic         hold,
    output logic [W-1:0] nxt
);
    logic signed [W+1:0] sum;
    logic signed [W+1:0] top;

    always_comb begin
        sum = $signed({2'b00, cur}) + $signed({{2{slope[W-1]}}, slope});
        top = $signed({2'b00, lim});
        if (hold)
            nxt = cur;
        else if (sum < 0)
            nxt = '0;
        else if (sum > top)
            nxt = lim;
        else
            nxt = sum[W-1:0];
    end
endmodule

// File: rtl/span_zcmp.sv
module span_zcmp #(
    parameter int W = 24
) (
    input  logic [W-1:0] cand,
    input  logic [W-1:0] stored,
    input  logic [2:0]   cond,
    output logic         pass
);
    logic lt, gt, eq;

    always_comb begin
        lt   = cand < stored;
        gt   = cand > stored;
        eq   = cand == stored;
        pass = (cond[2] & lt) | (cond[1] & gt) | (cond[0] & eq);
    end
endmodule

// File: rtl/span_interp.sv
module span_interp
    import span_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CNT_W-1:0]      span_cnt,
    input  logic [ADDR_W-1:0]     addr_start,
    input  logic [ZW-1:0]         z_start,
    input  logic [ZW-1:0]         z_slope,
    input  logic [CW-1:0]         r_start,
    input  logic [CW-1:0]         r_slope,
    input  logic [CW-1:0]         g_start,
    input  logic [CW-1:0]         g_slope,
    input  logic [CW-1:0]         b_start,
    input  logic [CW-1:0]         b_slope,
    input  logic [MASK_W-1:0]     sd_mask,
    input  logic [COND_W-1:0]     z_cond,
    input  logic                  z24_en,
    input  logic                  z_interp_off,
    input  logic                  c_interp_off,
    input  logic                  addr_hold,
    input  logic                  pseudo_en,
    input  logic [ZINT_WW-1:0]    fb_zold,
    output logic                  busy,
    output logic                  done,
    output logic [ADDR_W-1:0]     pix_addr,
    output logic                  fb_we,
    output logic [ZINT_WW-1:0]    fb_z,
    output logic [NCH*CINT_W-1:0] fb_rgb
);
    span_st_t               cur_q, nxt_d;
    logic [ZW-1:0]          zlim;
    logic [ZW-1:0]          z_step;
    logic [NCH-1:0][CW-1:0] c_step;
    logic [ZINT_WW-1:0]     z_int;
    logic                   z_pass;
    logic                   mask_ok;
    logic [CNT_W-1:0]       cnt_mag;

    assign zlim  = zlimit(cur_q.cfg.z24);
    assign z_int = cur_q.z[ZW-1:ZFRAC_W];

    span_satacc #(.W(ZW)) u_zacc (
        .cur   (cur_q.z),
        .slope (cur_q.cfg.zsl),
        .lim   (zlim),
        .hold  (cur_q.cfg.zoff),
        .nxt   (z_step)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        span_satacc #(.W(CW)) u_cacc (
            .cur   (cur_q.col[c]),
            .slope (cur_q.cfg.csl[c]),
            .lim   ({CW{1'b1}}),
            .hold  (cur_q.cfg.coff),
            .nxt   (c_step[c])
        );
        // channel 2 = red, 1 = green, 0 = blue; pseudo mode blanks the upper two
        if (c == 0) begin : g_keep
            assign fb_rgb[c*CINT_W +: CINT_W] = cur_q.col[c][CW-1:CFRAC_W];
        end else begin : g_blank
            assign fb_rgb[c*CINT_W +: CINT_W] =
                cur_q.cfg.pseudo ? '0 : cur_q.col[c][CW-1:CFRAC_W];
        end
    end

    span_zcmp #(.W(ZINT_WW)) u_zcmp (
        .cand   (z_int),
        .stored (fb_zold),
        .cond   (cur_q.cfg.cond),
        .pass   (z_pass)
    );

    assign mask_ok = cur_q.cfg.mask[cur_q.addr[MIDX_W-1:0]];

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        cnt_mag    = span_cnt[CNT_W-1] ? (~span_cnt + CNT_W'(1)) : span_cnt;
        if (!cur_q.busy) begin
            if (start) begin
                if (span_cnt == '0) begin
                    nxt_d.done = 1'b1;
                end else begin
                    nxt_d.busy       = 1'b1;
                    nxt_d.left       = cnt_mag;
                    nxt_d.addr       = addr_start;
                    nxt_d.z          = z_start & zlimit(z24_en);
                    nxt_d.col        = {r_start, g_start, b_start};
                    nxt_d.cfg.down   = span_cnt[CNT_W-1];
                    nxt_d.cfg.zsl    = z_slope;
                    nxt_d.cfg.csl    = {r_slope, g_slope, b_slope};
                    nxt_d.cfg.mask   = sd_mask;
                    nxt_d.cfg.cond   = z_cond;
                    nxt_d.cfg.z24    = z24_en;
                    nxt_d.cfg.zoff   = z_interp_off;
                    nxt_d.cfg.coff   = c_interp_off;
                    nxt_d.cfg.ahold  = addr_hold;
                    nxt_d.cfg.pseudo = pseudo_en;
                end
            end
        end else begin
            if (!cur_q.cfg.ahold)
                nxt_d.addr = cur_q.cfg.down ? cur_q.addr - ADDR_W'(1)
                                            : cur_q.addr + ADDR_W'(1);
            nxt_d.z    = z_step;
            nxt_d.col  = c_step;
            nxt_d.left = cur_q.left - CNT_W'(1);
            if (cur_q.left == CNT_W'(1)) begin
                nxt_d.busy = 1'b0;
                nxt_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign busy     = cur_q.busy;
    assign done     = cur_q.done;
    assign pix_addr = cur_q.addr;
    assign fb_z     = z_int;
    assign fb_we    = cur_q.busy & z_pass & mask_ok;
endmodule

// File: rtl/span_interp_chk.sv
module span_interp_chk
    import span_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  done,
    input logic                  fb_we,
    input logic [ADDR_W-1:0]     pix_addr,
    input logic [ZINT_WW-1:0]    fb_z,
    input logic [NCH*CINT_W-1:0] fb_rgb,
    input logic [MASK_W-1:0]     c_mask,
    input logic                  c_down,
    input logic                  c_hold,
    input logic                  c_pseudo,
    input logic                  c_z24
);
    // R1
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> busy);

    // R8
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_we |-> c_mask[pix_addr[MIDX_W-1:0]]);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            (pix_addr == (c_hold ? $past(pix_addr)
                        : c_down ? $past(pix_addr) - ADDR_W'(1)
                                 : $past(pix_addr) + ADDR_W'(1))));

    // R6
    pseudo_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && c_pseudo) |-> (fb_rgb[NCH*CINT_W-1:CINT_W] == '0));

    // R4
    narrow_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !c_z24) |-> (fb_z[ZINT_WW-1:ZINT_NW] == '0));
endmodule

bind span_interp span_interp_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .fb_we    (fb_we),
    .pix_addr (pix_addr),
    .fb_z     (fb_z),
    .fb_rgb   (fb_rgb),
    .c_mask   (cur_q.cfg.mask),
    .c_down   (cur_q.cfg.down),
    .c_hold   (cur_q.cfg.ahold),
    .c_pseudo (cur_q.cfg.pseudo),
    .c_z24    (cur_q.cfg.z24)
);

// File: tb/span_interp_tb.sv
module span_interp_tb;
    logic        clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, start;
    logic [12:0] span_cnt;
    logic [23:0] addr_start;
    logic [35:0] z_start, z_slope;
    logic [19:0] r_start, r_slope, g_start, g_slope, b_start, b_slope;
    logic [15:0] sd_mask;
    logic [2:0]  z_cond;
    logic        z24_en, z_interp_off, c_interp_off, addr_hold, pseudo_en;
    logic [23:0] fb_zold;
    logic        busy, done, fb_we;
    logic [23:0] pix_addr, fb_z, fb_rgb;

    span_interp u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .span_cnt(span_cnt),
        .addr_start(addr_start), .z_start(z_start), .z_slope(z_slope),
        .r_start(r_start), .r_slope(r_slope), .g_start(g_start), .g_slope(g_slope),
        .b_start(b_start), .b_slope(b_slope), .sd_mask(sd_mask), .z_cond(z_cond),
        .z24_en(z24_en), .z_interp_off(z_interp_off), .c_interp_off(c_interp_off),
        .addr_hold(addr_hold), .pseudo_en(pseudo_en), .fb_zold(fb_zold),
        .busy(busy), .done(done), .pix_addr(pix_addr), .fb_we(fb_we),
        .fb_z(fb_z), .fb_rgb(fb_rgb)
    );

    logic [23:0] zmem [64];
    logic [23:0] smem [64];
    assign fb_zold = zmem[pix_addr[5:0]];
    always @(posedge clk) if (fb_we) zmem[pix_addr[5:0]] <= fb_z;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;

    typedef struct {
        logic [23:0] a;
        logic        we;
        logic [23:0] z;
        logic [23:0] rgb;
    } px_t;
    px_t exq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard side
    always @(negedge clk) begin : mon
        px_t e;
        if (rst_n && !ended) begin
            if (busy) begin
                if (exq.size() == 0) begin
                    chk(0, "R1", "pixel beyond span", pix_addr, 0);
                end else begin
                    e = exq.pop_front();
                    chk(pix_addr == e.a, "R3", "address", pix_addr, e.a);
                    chk(fb_we == e.we, "R7 R8", "write enable", fb_we, e.we);
                    chk(fb_z == e.z, "R4", "depth", fb_z, e.z);
                    chk(fb_rgb == e.rgb, "R5 R6", "colour", fb_rgb, e.rgb);
                end
            end else begin
                chk(fb_we == 1'b0, "R9", "write while idle", fb_we, 0);
            end
        end
    end

    function automatic logic [35:0] satz(input logic [35:0] v, input logic [35:0] s,
                                         input logic [35:0] lim);
        longint x = longint'(v) + longint'($signed(s));
        if (x < 0) return '0;
        if (x > longint'(lim)) return lim;
        return x[35:0];
    endfunction

    function automatic logic [19:0] satc(input logic [19:0] v, input logic [19:0] s);
        longint x = longint'(v) + longint'($signed(s));
        if (x < 0) return '0;
        if (x > 64'hFFFFF) return 20'hFFFFF;
        return x[19:0];
    endfunction

    task automatic set_mem(input logic [23:0] v);
        for (int i = 0; i < 64; i++) begin
            zmem[i] = v;
            smem[i] = v;
        end
    endtask

    task automatic defaults();
        span_cnt = 13'd4; addr_start = 24'h10;
        z_start = 36'h0_0010_0000; z_slope = 36'h800;
        r_start = 20'h10000; r_slope = 20'h01800;
        g_start = 20'h00000; g_slope = 20'h01000;
        b_start = 20'hFF000; b_slope = 20'h00400;
        sd_mask = 16'hFFFF; z_cond = 3'b100; z24_en = 0;
        z_interp_off = 0; c_interp_off = 0; addr_hold = 0; pseudo_en = 0;
    endtask

    // driver: push the expected pixels of the span described by the inputs
    task automatic model();
        px_t e;
        int c, n;
        logic [23:0] a, zi, old;
        logic [35:0] lim, z;
        logic [19:0] r, g, b;
        logic pass;
        c   = int'($signed(span_cnt));
        n   = (c < 0) ? -c : c;
        a   = addr_start;
        lim = z24_en ? {36{1'b1}} : 36'h00FFFFFFF;
        z   = z_start & lim;
        r = r_start; g = g_start; b = b_start;
        for (int i = 0; i < n; i++) begin
            zi   = z[35:12];
            old  = smem[a[5:0]];
            pass = (z_cond[2] && zi < old) || (z_cond[1] && zi > old) ||
                   (z_cond[0] && zi == old);
            e.a  = a;
            e.we = pass && sd_mask[a[3:0]];
            e.z  = zi;
            e.rgb = {pseudo_en ? 8'h00 : r[19:12], pseudo_en ? 8'h00 : g[19:12], b[19:12]};
            if (e.we) smem[a[5:0]] = zi;
            exq.push_back(e);
            if (!addr_hold) a = (c < 0) ? a - 24'd1 : a + 24'd1;
            if (!z_interp_off) z = satz(z, z_slope, lim);
            if (!c_interp_off) begin
                r = satc(r, r_slope);
                g = satc(g, g_slope);
                b = satc(b, b_slope);
            end
        end
    endtask

    task automatic run(input bit poke);
        int c, n, cyc;
        logic [12:0] keep;
        c    = int'($signed(span_cnt));
        n    = (c < 0) ? -c : c;
        keep = span_cnt;
        model();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 5000) begin
            if (poke && cyc == 2) begin
                span_cnt = 13'd9;
                start    = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        span_cnt = keep;
        chk(cyc == n + 1, "R1", "cycles to done", cyc, n + 1);
        chk(exq.size() == 0, "R1", "pixels missing", exq.size(), 0);
        @(negedge clk);
        chk(!busy && !done, poke ? "R2" : "R1", "idle after span", {busy, done}, 0);
    endtask

    initial begin
        #4_000_000;
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        start = 0;
        defaults();
        set_mem(24'hFFFFFF);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fb_we, "R10", "reset state", {busy, done, fb_we}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !fb_we, "R10", "after release", {busy, done, fb_we}, 0);

        // R1 R3 R4 R5: ascending span, all writes pass
        span_cnt = 13'd6;
        run(0);
        // R3: descending span across address zero
        span_cnt = 13'h1FFB; addr_start = 24'h3;
        run(0);
        // R8: alternating screen-door pattern
        defaults(); span_cnt = 13'd8; addr_start = 24'h20; sd_mask = 16'hAAAA;
        run(0);
        // R7: equality, then greater-than against a stored plane
        defaults(); set_mem(24'h000200);
        z_start = 36'h0_0020_0000; z_slope = '0; z_cond = 3'b001; span_cnt = 13'd4;
        run(0);
        z_start = 36'h0_001F_F000; z_slope = 36'h1000; z_cond = 3'b010; addr_start = 24'h30;
        run(0);
        // R7: condition 0 never writes
        z_cond = 3'b000; addr_start = 24'h08;
        run(0);
        // R4 R5: clamping at both ends, narrow depth
        defaults(); z_cond = 3'b111;
        z_start = 36'h0_0FFF_0000; z_slope = 36'h0_0010_0000;
        r_start = 20'hFF000; r_slope = 20'h7FFFF;
        b_start = 20'h01000; b_slope = 20'hFE000;
        span_cnt = 13'd5;
        run(0);
        // R4: wide depth, stepping down and clamping at zero
        defaults(); set_mem(24'hFFFFFF); z24_en = 1;
        z_start = 36'h1_2345_6000; z_slope = 36'hF_FFFF_F000;
        run(0);
        z_start = 36'h0_0000_2000; addr_start = 24'h18;
        run(0);
        // R4 R5 R3: all three freezes, same address repeatedly
        defaults(); set_mem(24'hFFFFFF);
        z_interp_off = 1; c_interp_off = 1; addr_hold = 1; addr_start = 24'h05;
        run(0);
        // R6: pseudo colour
        defaults(); pseudo_en = 1; z_cond = 3'b111; span_cnt = 13'd3;
        run(0);
        // R1: zero count
        defaults(); span_cnt = 13'd0;
        run(0);
        // R2: start pulse while busy is ignored
        defaults(); z_cond = 3'b111; span_cnt = 13'd5; addr_start = 24'h28;
        run(1);

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule